// File: doc/BRIEF.md
# Cascaded H-Bridge State Splitter

This block takes one phase's overall switching level for a phase leg built from two series H-bridge cells. It produces the state of each cell and the four gate commands of each bridge. Each cell can drive its source voltage negative, zero or positive, and the phase voltage is the sum of the two cell outputs. The two cell supplies may stand in a 3:1 ratio, which gives nine distinct levels. They may instead stand in a 2:1 ratio, which gives seven levels, two of which can each be built in two ways. For these redundant levels the block picks the combination in which the low-voltage cell delivers power, never absorbs it, given the sign of the phase current.

Requests arrive on a valid/ready stream and leave through a single registered stage on a valid/ready stream. An upstream modulator offers a level, the ratio select and the current sign. The result appears one cycle after the transfer and stays put while the consumer holds `out_ready` low. `in_ready` is high whenever the output stage is empty or is being emptied in the same cycle, so a consumer that keeps `out_ready` high gets one result per cycle. Nothing is dropped and nothing is duplicated.

Top module: `chb_state_split`

## Requirements
- R1: With `in_ratio3`=1 (3:1 supplies), a level L in 0..8 gives high-cell state L/3 and low-cell state L mod 3.
- R2: With `in_ratio3`=0 (2:1 supplies), the non-redundant levels map as follows, with pairs written as (high, low):
  - 0 to (0,0)
  - 1 to (0,1)
  - 3 to (1,1)
  - 5 to (2,1)
  - 6 to (2,2)
- R3: With `in_ratio3`=0, level 4 gives (1,2) when `in_cur_pos`=1 and (2,0) when `in_cur_pos`=0.
- R4: With `in_ratio3`=0, level 2 gives (0,2) when `in_cur_pos`=1 and (1,0) when `in_cur_pos`=0. In both R3 and R4 the low cell delivers power.
- R5: A level above the top of the selected range is treated as the top level: 8 for 3:1 and 6 for 2:1.
- R6: Gate bit 0 drives the left high switch, bit 1 the left low switch, bit 2 the right high switch and bit 3 the right low switch. Cell state 2 drives 4'b1001, state 0 drives 4'b0110, and state 1 drives 4'b1010, with both low switches on.
- R7: No bridge leg ever has its high and low switch on together.
- R8: `in_ready` equals `!out_valid || out_ready`. An accepted request sets `out_valid` and appears on the outputs on the next cycle. `out_valid` clears after a transfer when no new request is accepted.
- R9: While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R10: During and after reset, `out_valid` is 0, both cell states are 1 and both gate words are 4'b1010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_level | input | LEVEL_W | Overall switching level |
| in_ratio3 | input | 1 | 1 selects 3:1 supplies, 0 selects 2:1 |
| in_cur_pos | input | 1 | 1 when the phase current is positive |
| out_valid | output | 1 | Result held on the outputs |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_s_hi | output | 2 | High-voltage cell state (0..2) |
| out_s_lo | output | 2 | Low-voltage cell state (0..2) |
| out_gate_hi | output | 4 | High-cell gate commands |
| out_gate_lo | output | 4 | Low-cell gate commands |

## Verification
The only state is the output register. If it is corrupted, the fault shows in the very cycle after the transfer: the cell states and gate words disagree with the level that was offered. For a wrong stall path, a result changes while `out_ready` is low, or `out_valid` drops early. A wrong steering choice for levels 2 and 4 stays invisible in the summed voltage but shows at once in the low-cell state. The bench therefore sweeps both current signs at both redundant levels and compares every cycle against a model that searches all cell pairs for the required sum.

// File: rtl/chb_pkg.sv
package chb_pkg;
  localparam int NCELL  = 2;
  localparam int GATE_W = 4;

  typedef logic [1:0] cell_st_t;
  localparam cell_st_t CELL_NEG  = 2'd0;
  localparam cell_st_t CELL_ZERO = 2'd1;
  localparam cell_st_t CELL_POS  = 2'd2;

  typedef struct packed {
    cell_st_t hi;
    cell_st_t lo;
  } cell_pair_t;
endpackage

// File: rtl/chb_level_map.sv
module chb_level_map import chb_pkg::*; #(
  parameter int LEVEL_W = 4
) (
  input  logic [LEVEL_W-1:0] level,
  input  logic               ratio3,
  input  logic               cur_pos,
  output cell_pair_t         pair
);
  localparam logic [LEVEL_W-1:0] TOP3 = LEVEL_W'(8);
  localparam logic [LEVEL_W-1:0] TOP2 = LEVEL_W'(6);

  logic [LEVEL_W-1:0] lim;
  logic [LEVEL_W-1:0] rem;

  always_comb begin
    if (ratio3) lim = (level > TOP3) ? TOP3 : level;
    else        lim = (level > TOP2) ? TOP2 : level;
  end

  always_comb begin
    pair = '{hi: CELL_ZERO, lo: CELL_ZERO};
    rem  = lim;
    if (ratio3) begin
      if (lim >= LEVEL_W'(6)) begin
        pair.hi = CELL_POS;
        rem     = lim - LEVEL_W'(6);
      end else if (lim >= LEVEL_W'(3)) begin
        pair.hi = CELL_ZERO;
        rem     = lim - LEVEL_W'(3);
      end else begin
        pair.hi = CELL_NEG;
      end
      pair.lo = rem[1:0];
    end else begin
      case (lim[2:0])
        3'd0: pair = '{hi: CELL_NEG,  lo: CELL_NEG};
        3'd1: pair = '{hi: CELL_NEG,  lo: CELL_ZERO};
        3'd2: pair = cur_pos ? '{hi: CELL_NEG,  lo: CELL_POS}
                             : '{hi: CELL_ZERO, lo: CELL_NEG};
        3'd3: pair = '{hi: CELL_ZERO, lo: CELL_ZERO};
        3'd4: pair = cur_pos ? '{hi: CELL_ZERO, lo: CELL_POS}
                             : '{hi: CELL_POS,  lo: CELL_NEG};
        3'd5: pair = '{hi: CELL_POS,  lo: CELL_ZERO};
        default: pair = '{hi: CELL_POS, lo: CELL_POS};
      endcase
    end
  end
endmodule

// File: rtl/chb_gate_drv.sv
module chb_gate_drv import chb_pkg::*; (
  input  cell_st_t          st,
  output logic [GATE_W-1:0] gates
);
  // bit0 left-high, bit1 left-low, bit2 right-high, bit3 right-low
  always_comb begin
    case (st)
      CELL_POS: gates = 4'b1001;
      CELL_NEG: gates = 4'b0110;
      default:  gates = 4'b1010;
    endcase
  end
endmodule

// File: rtl/chb_state_split.sv
module chb_state_split import chb_pkg::*; #(
  parameter int LEVEL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LEVEL_W-1:0] in_level,
  input  logic               in_ratio3,
  input  logic               in_cur_pos,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_s_hi,
  output logic [1:0]         out_s_lo,
  output logic [GATE_W-1:0]  out_gate_hi,
  output logic [GATE_W-1:0]  out_gate_lo
);
  cell_pair_t map_pair;
  cell_pair_t pair_q;
  logic       valid_q;
  logic       take;

  logic [NCELL-1:0][1:0]        st_vec;
  logic [NCELL-1:0][GATE_W-1:0] gate_vec;

  chb_level_map #(.LEVEL_W(LEVEL_W)) u_map (
    .level   (in_level),
    .ratio3  (in_ratio3),
    .cur_pos (in_cur_pos),
    .pair    (map_pair)
  );

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pair_q  <= '{hi: CELL_ZERO, lo: CELL_ZERO};
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        pair_q  <= map_pair;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign st_vec[1] = pair_q.hi;
  assign st_vec[0] = pair_q.lo;

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    chb_gate_drv u_drv (
      .st    (st_vec[g]),
      .gates (gate_vec[g])
    );
  end

  assign out_valid   = valid_q;
  assign out_s_hi    = pair_q.hi;
  assign out_s_lo    = pair_q.lo;
  assign out_gate_hi = gate_vec[1];
  assign out_gate_lo = gate_vec[0];
endmodule

// File: rtl/chb_state_split_chk.sv
module chb_state_split_chk #(
  parameter int LEVEL_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [LEVEL_W-1:0] in_level,
  input logic               in_ratio3,
  input logic               in_cur_pos,
  input logic               out_valid,
  input logic               out_ready,
  input logic [1:0]         out_s_hi,
  input logic [1:0]         out_s_lo,
  input logic [3:0]         out_gate_hi,
  input logic [3:0]         out_gate_lo
);
  logic [LEVEL_W-1:0] lim_in;
  always_comb begin
    if (in_ratio3) lim_in = (in_level > LEVEL_W'(8)) ? LEVEL_W'(8) : in_level;
    else           lim_in = (in_level > LEVEL_W'(6)) ? LEVEL_W'(6) : in_level;
  end

  // R1
  level_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      ((($past(in_ratio3) ? 5'(out_s_hi) * 5'd3 : 5'(out_s_hi) * 5'd2) + 5'(out_s_lo))
        == 5'($past(lim_in))));

  // R3
  steer_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_ratio3 && in_level == LEVEL_W'(4)) |=>
      (out_s_lo == ($past(in_cur_pos) ? 2'd2 : 2'd0)));

  // R7
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_gate_hi[0] && out_gate_hi[1]) && !(out_gate_hi[2] && out_gate_hi[3]) &&
    !(out_gate_lo[0] && out_gate_lo[1]) && !(out_gate_lo[2] && out_gate_lo[3]));

  // R8
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_s_hi) && $stable(out_s_lo) &&
       $stable(out_gate_hi) && $stable(out_gate_lo)));

  // R1
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_s_hi != 2'd3) && (out_s_lo != 2'd3));
endmodule

bind chb_state_split chb_state_split_chk #(.LEVEL_W(LEVEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_level    (in_level),
  .in_ratio3   (in_ratio3),
  .in_cur_pos  (in_cur_pos),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_s_hi    (out_s_hi),
  .out_s_lo    (out_s_lo),
  .out_gate_hi (out_gate_hi),
  .out_gate_lo (out_gate_lo)
);

// File: tb/sim_chb_state_split.sv
module sim_chb_state_split;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          in_valid = 1'b0, in_ratio3 = 1'b0, in_cur_pos = 1'b0, out_ready = 1'b0;
  logic [LW-1:0] in_level = '0;
  logic          in_ready, out_valid;
  logic [1:0]    out_s_hi, out_s_lo;
  logic [3:0]    out_gate_hi, out_gate_lo;

  chb_state_split #(.LEVEL_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_level(in_level), .in_ratio3(in_ratio3), .in_cur_pos(in_cur_pos),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_s_hi(out_s_hi), .out_s_lo(out_s_lo),
    .out_gate_hi(out_gate_hi), .out_gate_lo(out_gate_lo)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int hi; int lo; string tag; } item_t;
  item_t q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Search every (hi, lo) pair for the required sum; for two candidates keep
  // the one where the low cell delivers power (sign of lo voltage matches current).
  function automatic item_t ref_map(int lvl, bit r3, bit pos);
    item_t it;
    int top = r3 ? 8 : 6;
    int w   = r3 ? 3 : 2;
    int dir = pos ? 1 : -1;
    int found = 0;
    it.tag = r3 ? ((lvl > 8) ? "R5" : "R1")
                : ((lvl > 6) ? "R5" : (lvl == 4) ? "R3" : (lvl == 2) ? "R4" : "R2");
    if (lvl > top) lvl = top;
    it.hi = -1; it.lo = -1;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        if (w * a + b == lvl)
          if (found == 0 || (b - 1) * dir > 0) begin
            it.hi = a; it.lo = b; found++;
          end
    return it;
  endfunction

  function automatic int gate_of(int s);
    if (s == 2) return 4'b1001;
    if (s == 0) return 4'b0110;
    return 4'b1010;
  endfunction

  task automatic leg_check(input logic [3:0] g, input string what);
    check(!(g[0] && g[1]) && !(g[2] && g[3]), "R7", what, int'(g), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit stalled = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10", "out_valid", int'(out_valid), 0);
    check(out_s_hi == 2'd1, "R10", "s_hi", int'(out_s_hi), 1);
    check(out_s_lo == 2'd1, "R10", "s_lo", int'(out_s_lo), 1);
    check(out_gate_hi == 4'b1010, "R10", "gate_hi", int'(out_gate_hi), 10);
    check(out_gate_lo == 4'b1010, "R10", "gate_lo", int'(out_gate_lo), 10);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      check(out_valid == (q.size() > 0), "R8", "out_valid", int'(out_valid), int'(q.size() > 0));
      if (q.size() > 0 && out_valid) begin
        string t = stalled ? "R9" : q[0].tag;
        check(int'(out_s_hi) == q[0].hi, t, "s_hi", int'(out_s_hi), q[0].hi);
        check(int'(out_s_lo) == q[0].lo, t, "s_lo", int'(out_s_lo), q[0].lo);
        check(int'(out_gate_hi) == gate_of(q[0].hi), "R6", "gate_hi", int'(out_gate_hi), gate_of(q[0].hi));
        check(int'(out_gate_lo) == gate_of(q[0].lo), "R6", "gate_lo", int'(out_gate_lo), gate_of(q[0].lo));
      end
      leg_check(out_gate_hi, "gate_hi legs");
      leg_check(out_gate_lo, "gate_lo legs");

      if (cyc < 64) begin
        in_valid   = 1'b1;
        out_ready  = 1'b1;
        in_level   = LW'(cyc % 16);
        in_ratio3  = ((cyc / 16) % 2) == 1;
        in_cur_pos = (cyc / 32) == 1;
      end else begin
        in_valid   = ($urandom % 4) != 0;
        out_ready  = ($urandom % 3) != 0;
        in_level   = LW'($urandom % 16);
        in_ratio3  = $urandom % 2;
        in_cur_pos = $urandom % 2;
      end
      #1;
      check(in_ready == (q.size() == 0 || out_ready), "R8", "in_ready",
            int'(in_ready), int'(q.size() == 0 || out_ready));

      stalled = (q.size() > 0) && !out_ready;
      if (q.size() > 0 && out_ready) void'(q.pop_front());
      if (in_valid && (q.size() == 0))
        q.push_back(ref_map(int'(in_level), in_ratio3, in_cur_pos));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule